// File: doc/BRIEF.md
# Circular Return Address Stack

This block is the call/return stack of a small microcontroller core. It holds saved program counter values in a ring of register stages and selects one of them with a stack pointer. The default is four stages with a 2-bit pointer. A call request moves the pointer forward first and then stores the supplied program counter in the stage it now selects. The returned program counter is always driven combinationally from the selected stage, so the core can load it in the same cycle it raises a return request. The pointer then steps back one position at the clock edge.

The pointer never saturates, and it has no overflow or underflow signal. A fifth nested call wraps the pointer from the top stage to stage 0 and overwrites the oldest saved entry. A return taken at stage 0 wraps the pointer to the top stage. Both reset and the wake input (used when leaving the low-power retention or standby state) put the pointer at the top stage, so the next call writes stage 0. Neither of them clears the stored entries.

Top module: `ret_addr_stack`

## Requirements
- R1: The default configuration has four stages and a 2-bit pointer. An active-low asynchronous reset forces the pointer to 3 (the top stage) at once, so the first call after reset writes stage 0.
- R2: On a call request alone, the pointer becomes (pointer + 1) mod 4 at the clock edge, and call_pc is written into that newly selected stage. From the next cycle, ret_pc shows the value just pushed.
- R3: ret_pc always equals the contents of the selected stage, combinationally, including in the cycle a return request is high. On a return request, the pointer becomes (pointer - 1) mod 4 at the clock edge.
- R4: A call made with the pointer at 3 wraps the pointer to 0 and overwrites stage 0 (the oldest entry), with no error indication.
- R5: A return made with the pointer at 0 delivers stage 0 and wraps the pointer to 3, with no underflow indication.
- R6: When call and return requests are high in the same cycle, only the return takes effect. call_pc is not stored anywhere, and the pointer steps back by one.
- R7: A high wake input forces the pointer to 3 at the clock edge. Wake takes precedence over call and return requests, and no stage is written in that cycle.
- R8: Neither reset nor wake changes the stage contents. After either one, ret_pc shows whatever stage 3 last held.
- R9: In a cycle with no request, the pointer and all stages keep their values, and ret_pc is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the pointer |
| wake | input | 1 | Synchronous pointer reinitialisation on leaving a low-power state |
| call_req | input | 1 | Single-cycle call request (push) |
| ret_req | input | 1 | Single-cycle return request (pop) |
| call_pc | input | PC_W (13) | Program counter value to save on a call |
| ret_pc | output | PC_W (13) | Contents of the selected stage (restored program counter) |

## Verification
On every cycle, the embedded properties check the pointer arithmetic for each request kind: the forward and backward wrap at the ends, the precedence of wake, and the pointer value straight after reset. They also check that at most one stage is written per edge, that every other stage holds its value, and that a lone call is visible on ret_pc in the next cycle. Other behaviours depend on a history of stored entries, and only the bench's scenarios can show them. These are the loss of the oldest entry after a fifth call, the LIFO order of the values returned, the fact that a simultaneous call leaves no trace deeper in the stack, and the retention of contents through wake and reset. The bench checks these against a reference model it keeps itself.

// File: rtl/ras_pkg.sv
package ras_pkg;

   // Operation applied to the stack in one cycle, after priority resolution.
   typedef enum logic [1:0] {
      RAS_IDLE = 2'd0,
      RAS_PUSH = 2'd1,
      RAS_POP  = 2'd2,
      RAS_WAKE = 2'd3
   } ras_op_e;

   // Wake beats return, and return beats call.
   function automatic ras_op_e ras_decode(input logic wake_i,
                                          input logic call_i,
                                          input logic ret_i);
      if (wake_i)
         return RAS_WAKE;
      else if (ret_i)
         return RAS_POP;
      else if (call_i)
         return RAS_PUSH;
      else
         return RAS_IDLE;
   endfunction

endpackage

// File: rtl/ras_ptr.sv
module ras_ptr
   import ras_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ras_op_e          op,
   output logic [PTR_W-1:0] ptr,
   output logic [PTR_W-1:0] ptr_inc
);

   localparam logic [PTR_W-1:0] TOP = PTR_W'(DEPTH - 1);

   logic [PTR_W-1:0] ptr_dec;

   // DEPTH is a power of two, so the adders wrap without extra logic.
   assign ptr_inc = ptr + 1'b1;
   assign ptr_dec = ptr - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= TOP;
      else begin
         case (op)
            RAS_PUSH: ptr <= ptr_inc;
            RAS_POP:  ptr <= ptr_dec;
            RAS_WAKE: ptr <= TOP;
            default:  ptr <= ptr;
         endcase
      end
   end

   p_reset_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ptr == TOP);

   p_push_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
      op == RAS_PUSH |=> ptr == PTR_W'($past(ptr) + 1'b1));

   p_pop_retreat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      op == RAS_POP |=> ptr == PTR_W'($past(ptr) - 1'b1));

   p_push_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op == RAS_PUSH && ptr == TOP) |=> ptr == '0);

   p_pop_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op == RAS_POP && ptr == '0) |=> ptr == TOP);

   p_wake_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
      op == RAS_WAKE |=> ptr == TOP);

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      op == RAS_IDLE |=> $stable(ptr));

endmodule

// File: rtl/ras_bank.sv
module ras_bank #(
   parameter int DEPTH = 4,
   parameter int PC_W  = 13,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [PTR_W-1:0]            wr_idx,
   input  logic [PC_W-1:0]             wr_data,
   output logic [DEPTH-1:0][PC_W-1:0]  stage
);

   logic [DEPTH-1:0] sel;

   // One register stage per entry; no reset, contents survive reset and wake.
   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      assign sel[i] = wr_en && (wr_idx == PTR_W'(i));

      always_ff @(posedge clk) begin
         if (sel[i])
            stage[i] <= wr_data;
      end

      p_stage_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !sel[i] |=> $stable(stage[i]));
   end

   p_one_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));

endmodule

// File: rtl/ras_rdmux.sv
module ras_rdmux #(
   parameter int DEPTH       = 4,
   parameter int PC_W        = 13,
   parameter bit ONEHOT_READ = 1'b0,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0][PC_W-1:0] stage,
   input  logic [PTR_W-1:0]           rd_idx,
   output logic [PC_W-1:0]            rd_data
);

   if (ONEHOT_READ) begin : g_andor
      // Flat AND-OR tree: one gate level per stage, no decoder chain.
      always_comb begin
         rd_data = '0;
         for (int k = 0; k < DEPTH; k++)
            rd_data = rd_data | (stage[k] & {PC_W{rd_idx == PTR_W'(k)}});
      end
   end else begin : g_index
      assign rd_data = stage[rd_idx];
   end

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
   import ras_pkg::*;
#(
   parameter int PC_W        = 13,
   parameter int DEPTH       = 4,
   parameter bit ONEHOT_READ = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wake,
   input  logic            call_req,
   input  logic            ret_req,
   input  logic [PC_W-1:0] call_pc,
   output logic [PC_W-1:0] ret_pc
);

   localparam int PTR_W = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("ret_addr_stack: DEPTH must be a power of two of at least 2");
   end
   if (PC_W < 1) begin : g_bad_width
      $error("ret_addr_stack: PC_W must be at least 1");
   end

   ras_op_e                      op;
   logic [PTR_W-1:0]             ptr;
   logic [PTR_W-1:0]             ptr_inc;
   logic [DEPTH-1:0][PC_W-1:0]   stage;

   assign op = ras_decode(wake, call_req, ret_req);

   ras_ptr #(.DEPTH(DEPTH)) i_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op),
      .ptr     (ptr),
      .ptr_inc (ptr_inc)
   );

   // A push writes the stage the advanced pointer will select.
   ras_bank #(.DEPTH(DEPTH), .PC_W(PC_W)) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (op == RAS_PUSH),
      .wr_idx  (ptr_inc),
      .wr_data (call_pc),
      .stage   (stage)
   );

   ras_rdmux #(.DEPTH(DEPTH), .PC_W(PC_W), .ONEHOT_READ(ONEHOT_READ)) i_rdmux (
      .stage   (stage),
      .rd_idx  (ptr),
      .rd_data (ret_pc)
   );

   p_call_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (call_req && !ret_req && !wake) |=> ret_pc == $past(call_pc));

   p_idle_output_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!call_req && !ret_req && !wake) |=> $stable(ret_pc));

endmodule

// File: tb/test_ret_addr_stack.sv
module test_ret_addr_stack;

   localparam int PCW = 13;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wake = 1'b0;
   logic           call_req = 1'b0;
   logic           ret_req = 1'b0;
   logic [PCW-1:0] call_pc = '0;
   logic [PCW-1:0] ret_pc;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Reference model of the stack.
   logic [PCW-1:0] m_stk [4];
   bit             m_ok  [4];
   int             m_ptr = 3;

   always #10 clk = ~clk;

   ret_addr_stack #(.PC_W(PCW), .DEPTH(4)) i_ret_addr_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .wake     (wake),
      .call_req (call_req),
      .ret_req  (ret_req),
      .call_pc  (call_pc),
      .ret_pc   (ret_pc)
   );

   task automatic chk(input logic [PCW-1:0] act, input logic [PCW-1:0] exp,
                      input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: ret_pc=%h expected %h", tag, act, exp);
      end
   endtask

   function automatic int next_ptr(input int p, input bit c, input bit r,
                                   input bit w);
      if (w)      return 3;
      else if (r) return (p + 3) % 4;
      else if (c) return (p + 1) % 4;
      else        return p;
   endfunction

   // One cycle: drive at negedge, check same-cycle output, update model at edge.
   task automatic apply(input bit c, input bit r, input bit w,
                        input logic [PCW-1:0] pc, input string tag);
      @(negedge clk);
      call_req = c; ret_req = r; wake = w; call_pc = pc;
      #1;
      if (m_ok[m_ptr]) chk(ret_pc, m_stk[m_ptr], tag);
      @(posedge clk);
      m_ptr = next_ptr(m_ptr, c, r, w);
      if (c && !r && !w) begin
         m_stk[m_ptr] = pc;
         m_ok[m_ptr]  = 1'b1;
      end
   endtask

   task automatic expect_top(input logic [PCW-1:0] exp, input string tag);
      #1;
      chk(ret_pc, exp, tag);
   endtask

   task automatic idle();
      @(negedge clk);
      call_req = 0; ret_req = 0; wake = 0;
   endtask

   localparam logic [PCW-1:0] VA = 13'h0A1, VB = 13'h1B2, VC = 13'h0C3,
                              VD = 13'h1D4, VE = 13'h0E5, VF = 13'h1F6,
                              VG = 13'h017, VH = 13'h128;

   initial begin
      for (int i = 0; i < 4; i++) m_ok[i] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R2: four calls fill the stages in order
      apply(1, 0, 0, VA, "R1"); expect_top(VA, "R1 first call");
      apply(1, 0, 0, VB, "R2"); expect_top(VB, "R2 push");
      apply(1, 0, 0, VC, "R2"); expect_top(VC, "R2 push");
      apply(1, 0, 0, VD, "R2"); expect_top(VD, "R2 push");
      // R4: fifth call overwrites stage 0
      apply(1, 0, 0, VE, "R4"); expect_top(VE, "R4 wrap push");
      // R3: returns in LIFO order, same-cycle output checked in apply
      apply(0, 1, 0, '0, "R3"); expect_top(VD, "R3 pop");
      apply(0, 1, 0, '0, "R3"); expect_top(VC, "R3 pop");
      apply(0, 1, 0, '0, "R3"); expect_top(VB, "R3 pop");
      apply(0, 1, 0, '0, "R3"); expect_top(VE, "R4 oldest lost");
      // R5: return at stage 0 wraps to 3
      apply(0, 1, 0, '0, "R5"); expect_top(VD, "R5 pop wrap");
      // R7 / R8: wake mid-stack, with a competing call
      apply(1, 0, 0, VF, "R2"); expect_top(VF, "R2 push");
      apply(1, 0, 0, VG, "R2"); expect_top(VG, "R2 push");
      apply(1, 0, 1, VH, "R7"); expect_top(VD, "R7 wake to top");
      apply(0, 1, 0, '0, "R8"); expect_top(VC, "R8 retained");
      apply(0, 1, 0, '0, "R7"); expect_top(VG, "R7 no write on wake");
      apply(0, 1, 0, '0, "R7"); expect_top(VF, "R7 no write on wake");
      // R6: call and return together, pointer at 0
      apply(1, 1, 0, VH, "R6"); expect_top(VD, "R6 return wins");
      apply(0, 1, 0, '0, "R6"); expect_top(VC, "R6 call not stored");
      // R9: idle cycles
      for (int i = 0; i < 3; i++) begin
         apply(0, 0, 0, VA, "R9"); expect_top(VC, "R9 idle hold");
      end
      // R1 / R8: asynchronous reset mid-run, contents kept
      @(negedge clk);
      rst_n = 1'b0;
      #3;
      chk(ret_pc, VD, "R1 async reset to top");
      m_ptr = 3;
      @(negedge clk);
      rst_n = 1'b1;
      expect_top(VD, "R8 retained over reset");

      // Constrained random phase against the model
      void'($urandom(32'd1357));
      for (int n = 0; n < 400; n++) begin
         int sel;
         logic [PCW-1:0] pc;
         sel = int'($urandom % 100);
         pc  = PCW'($urandom);
         if (sel < 40)      apply(1, 0, 0, pc, "R2 random");
         else if (sel < 75) apply(0, 1, 0, pc, "R3 random");
         else if (sel < 85) apply(1, 1, 0, pc, "R6 random");
         else if (sel < 90) apply(sel[0], sel[1], 1, pc, "R7 random");
         else               apply(0, 0, 0, pc, "R9 random");
         if (m_ok[m_ptr]) expect_top(m_stk[m_ptr], "R3 random after edge");
      end
      idle();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #4_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: ret_pc=%h expected run end", ret_pc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule